// File: doc/BRIEF.md
# Host Register Window Port

This block gives a 16-bit host bus access to a device's internal register and buffer space along two paths. On the I/O path the host uses eight word offsets. One offset holds a pointer into the internal space, two data offsets read and write the word at that pointer and the word after it, and the remaining offsets are shortcuts: sequential transmit/receive buffer ports, the transmit command word, the transmit length word, and an event queue that is popped by reading it. On the memory path, which is enabled by a control word inside the internal space, the whole internal space appears inside a 4 KB page of host memory space, and the page is chosen by another control word.

Every host access, on either path, becomes one internal access per cycle. Reads return their data one cycle later together with a valid pulse. The host bus has no back-pressure, so a read always completes on the following cycle. Internal events enter the queue over a valid/ready stream. `evt_ready` drops while the queue is full, and a word is taken only in a cycle where `evt_valid` and `evt_ready` are both high. The producer must hold its word until it is taken.

Top module: `regwin`

## Requirements
- R1: After reset the block is in I/O mode: the pointer reads 0, the event queue is empty, `evt_ready` is 1, and memory strobes produce no `rd_valid` while bit 0 of internal word 0x0020 is 0.
- R2: An I/O write to offset 0x0A stores the pointer with bit 0 forced to 0. An I/O read of 0x0A returns the stored pointer. The pointer never increments by itself.
- R3: An I/O access at offset 0x0C reaches the internal word at the pointer address. An I/O access at offset 0x0E reaches the internal word at pointer+2.
- R4: I/O offsets 0x04 and 0x06 share storage with internal words 0x0144 and 0x0146, so a write on either path is seen on every path.
- R5: A read of I/O offset 0x08, or of internal address 0x0120 on any path, returns the oldest queued event word and removes it. A read of an empty queue returns 0.
- R6: The event input is valid/ready. `evt_ready` is 0 exactly while ISQ_DEPTH words are held, and a word offered while `evt_ready` is 0 is not stored.
- R7: When bit 0 of internal word 0x0020 is 1, a memory strobe whose `host_addr[19:12]` equals bits [7:0] of internal word 0x0022 accesses internal address `host_addr[11:0]`. A memory strobe outside that page is ignored.
- R8: Only these internal words are mapped: 0x0000–0x0045, 0x0100–0x013F except 0x0120, 0x0144–0x0147, 0x0150–0x0159, 0x0400 plus 2·RX_WORDS bytes, and 0x0A00 plus 2·TX_WORDS bytes. Any other address, including 0x1000 and above, reads as 0 and ignores writes.
- R9: I/O writes to offsets 0x00 or 0x02 fill the transmit area word by word from 0x0A00 and wrap after TX_WORDS words. Any write of the transmit command word, on either path, returns the fill position to 0x0A00.
- R10: I/O reads of offsets 0x00 or 0x02 return receive area words in order from 0x0400 and wrap after RX_WORDS words.
- R11: Read data appears with a one-cycle `rd_valid` pulse on the cycle after the strobe. Only one access is made per cycle, chosen in the order `io_wr`, `io_rd`, `mem_wr`, `mem_rd`.
- R12: Writes to I/O offset 0x08 and to internal address 0x0120 leave the event queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 4 | I/O byte offset (bit 0 ignored) |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| host_addr | input | HAW (20) | Host memory address |
| wr_data | input | 16 | Write data for either path |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | 16 | Read data |
| evt_valid | input | 1 | Event word offered |
| evt_ready | output | 1 | Event queue can accept a word |
| evt_data | input | 16 | Event word |

## Verification
The hardest situations to reach from the ports are the queue being full while a producer keeps offering a word, and the pop-by-read being reached through its internal alias rather than its offset. The stimulus fills the queue through the stream until `evt_ready` falls, offers one extra word that must be refused, and then drains the queue. The drain alternates between the queue offset and a pointer read of 0x0120, and places ignored writes to both between the reads. Memory-path decoding is reached by first writing the page and enable words through the pointer, then issuing memory strobes inside and outside the page. Simultaneous strobes are also driven to check the priority order.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam logic [15:0] A_MODE   = 16'h0020;
  localparam logic [15:0] A_PAGE   = 16'h0022;
  localparam logic [15:0] A_ISQ    = 16'h0120;
  localparam logic [15:0] A_TXCMD  = 16'h0144;
  localparam logic [15:0] A_TXLEN  = 16'h0146;
  localparam logic [15:0] A_RXBASE = 16'h0400;
  localparam logic [15:0] A_TXBASE = 16'h0A00;

  typedef enum logic [2:0] {
    SLOT_DATA0 = 3'd0,
    SLOT_DATA1 = 3'd1,
    SLOT_TXCMD = 3'd2,
    SLOT_TXLEN = 3'd3,
    SLOT_ISQ   = 3'd4,
    SLOT_PTR   = 3'd5,
    SLOT_WLO   = 3'd6,
    SLOT_WHI   = 3'd7
  } io_slot_e;

  typedef struct packed {
    logic        vld;
    logic        wr;
    logic        io;
    logic [2:0]  slot;
    logic [11:0] maddr;
    logic [15:0] wdata;
  } acc_t;

endpackage

// File: rtl/regwin_arb.sv
module regwin_arb
  import regwin_pkg::*;
#(
  parameter int HAW = 20
) (
  input  logic           io_rd,
  input  logic           io_wr,
  input  logic [3:0]     io_addr,
  input  logic           mem_rd,
  input  logic           mem_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [15:0]    wr_data,
  input  logic           mem_en,
  input  logic [HAW-13:0] page,
  output acc_t           acc
);

  logic mem_hit;

  always_comb begin
    mem_hit   = mem_en && (host_addr[HAW-1:12] == page);
    acc       = '0;
    acc.slot  = io_addr[3:1];
    acc.maddr = host_addr[11:0];
    acc.wdata = wr_data;
    if (io_wr) begin
      acc.vld = 1'b1; acc.wr = 1'b1; acc.io = 1'b1;
    end else if (io_rd) begin
      acc.vld = 1'b1; acc.io = 1'b1;
    end else if (mem_wr && mem_hit) begin
      acc.vld = 1'b1; acc.wr = 1'b1;
    end else if (mem_rd && mem_hit) begin
      acc.vld = 1'b1;
    end
  end

endmodule

// File: rtl/regwin_store.sv
module regwin_store
  import regwin_pkg::*;
#(
  parameter int RX_WORDS = 16,
  parameter int TX_WORDS = 16,
  parameter int PW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   addr,
  input  logic          wr_en,
  input  logic [15:0]   wdata,
  output logic          hit,
  output logic [15:0]   rdata,
  output logic          mem_en,
  output logic [PW-1:0] page
);

  // word-index bounds of each mapped region
  localparam int unsigned BUS_LO = 0,    BUS_HI = 'h22;
  localparam int unsigned ST_LO  = 'h80, ST_HI  = 'h9F;
  localparam int unsigned TC_LO  = 'hA2, TC_HI  = 'hA3;
  localparam int unsigned FL_LO  = 'hA8, FL_HI  = 'hAC;
  localparam int unsigned RX_LO  = int'(A_RXBASE) / 2;
  localparam int unsigned TX_LO  = int'(A_TXBASE) / 2;
  localparam int unsigned ISQ_W  = int'(A_ISQ) / 2;

  localparam int unsigned ST_OFF = BUS_HI - BUS_LO + 1;
  localparam int unsigned TC_OFF = ST_OFF + (ST_HI - ST_LO + 1);
  localparam int unsigned FL_OFF = TC_OFF + (TC_HI - TC_LO + 1);
  localparam int unsigned RX_OFF = FL_OFF + (FL_HI - FL_LO + 1);
  localparam int unsigned TX_OFF = RX_OFF + RX_WORDS;
  localparam int unsigned NW     = TX_OFF + TX_WORDS;
  localparam int          IW     = $clog2(NW);
  localparam int unsigned MODE_I = int'(A_MODE) / 2;
  localparam int unsigned PAGE_I = int'(A_PAGE) / 2;

  logic [15:0]   mem_q [NW];
  logic [IW-1:0] idx;
  int unsigned   wi;

  always_comb begin
    wi  = int'(addr[15:1]);
    hit = 1'b1;
    idx = '0;
    if (wi <= BUS_HI)
      idx = IW'(wi);
    else if (wi >= ST_LO && wi <= ST_HI && wi != ISQ_W)
      idx = IW'(ST_OFF + wi - ST_LO);
    else if (wi >= TC_LO && wi <= TC_HI)
      idx = IW'(TC_OFF + wi - TC_LO);
    else if (wi >= FL_LO && wi <= FL_HI)
      idx = IW'(FL_OFF + wi - FL_LO);
    else if (wi >= RX_LO && wi < RX_LO + RX_WORDS)
      idx = IW'(RX_OFF + wi - RX_LO);
    else if (wi >= TX_LO && wi < TX_LO + TX_WORDS)
      idx = IW'(TX_OFF + wi - TX_LO);
    else
      hit = 1'b0;
  end

  assign rdata  = hit ? mem_q[idx] : 16'h0000;
  assign mem_en = mem_q[MODE_I][0];
  assign page   = mem_q[PAGE_I][PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '0;
    end else if (wr_en && hit) begin
      mem_q[idx] <= wdata;
    end
  end

endmodule

// File: rtl/regwin_evq.sv
module regwin_evq #(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_data,
  input  logic                       pop,
  output logic                       empty,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PIW = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [DW-1:0]  buf_q [DEPTH];
  logic [PIW-1:0] wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic           push, take;

  assign in_ready = (cnt_q != CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign head     = buf_q[rp_q];
  assign count    = cnt_q;
  assign push     = in_valid && in_ready;
  assign take     = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      if (push) begin
        buf_q[wp_q] <= in_data;
        wp_q <= (wp_q == PIW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (take) rp_q <= (rp_q == PIW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (push && !take)      cnt_q <= cnt_q + 1'b1;
      else if (take && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/regwin.sv
module regwin
  import regwin_pkg::*;
#(
  parameter int HAW       = 20,
  parameter int RX_WORDS  = 16,
  parameter int TX_WORDS  = 16,
  parameter int ISQ_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_rd,
  input  logic           io_wr,
  input  logic [3:0]     io_addr,
  input  logic           mem_rd,
  input  logic           mem_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [15:0]    wr_data,
  output logic           rd_valid,
  output logic [15:0]    rd_data,
  input  logic           evt_valid,
  output logic           evt_ready,
  input  logic [15:0]    evt_data
);

  localparam int PW  = HAW - 12;
  localparam int RXI = $clog2(RX_WORDS);
  localparam int TXI = $clog2(TX_WORDS);
  localparam int CW  = $clog2(ISQ_DEPTH + 1);

  acc_t           acc;
  io_slot_e       slot;
  logic           mem_en;
  logic [PW-1:0]  page;
  logic [15:0]    ptr_q;
  logic [RXI-1:0] rx_idx_q;
  logic [TXI-1:0] tx_idx_q;
  logic [15:0]    st_addr, st_rdata, rd_next, q_head;
  logic           st_hit, st_wr, use_store, is_isq, is_ptr, is_dport;
  logic           pop, q_empty;
  logic [CW-1:0]  q_count;

  regwin_arb #(.HAW(HAW)) u_arb (
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .host_addr(host_addr),
    .wr_data(wr_data), .mem_en(mem_en), .page(page), .acc(acc)
  );

  always_comb begin
    slot      = io_slot_e'(acc.slot);
    st_addr   = {4'h0, acc.maddr};
    use_store = 1'b1;
    is_isq    = 1'b0;
    is_ptr    = 1'b0;
    is_dport  = 1'b0;
    if (acc.io) begin
      unique case (slot)
        SLOT_DATA0, SLOT_DATA1: begin
          is_dport = 1'b1;
          st_addr  = acc.wr ? A_TXBASE + 16'({tx_idx_q, 1'b0})
                            : A_RXBASE + 16'({rx_idx_q, 1'b0});
        end
        SLOT_TXCMD: st_addr = A_TXCMD;
        SLOT_TXLEN: st_addr = A_TXLEN;
        SLOT_ISQ:   begin use_store = 1'b0; is_isq = 1'b1; end
        SLOT_PTR:   begin use_store = 1'b0; is_ptr = 1'b1; end
        SLOT_WLO:   st_addr = ptr_q;
        SLOT_WHI:   st_addr = ptr_q + 16'd2;
        default:    st_addr = ptr_q;
      endcase
    end
    if (use_store && st_addr[15:1] == A_ISQ[15:1]) is_isq = 1'b1;
    st_wr   = acc.vld && acc.wr && use_store;
    pop     = acc.vld && !acc.wr && is_isq;
    if (is_ptr)      rd_next = ptr_q;
    else if (is_isq) rd_next = q_empty ? 16'h0000 : q_head;
    else             rd_next = st_hit ? st_rdata : 16'h0000;
  end

  regwin_store #(.RX_WORDS(RX_WORDS), .TX_WORDS(TX_WORDS), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(st_addr), .wr_en(st_wr),
    .wdata(acc.wdata), .hit(st_hit), .rdata(st_rdata),
    .mem_en(mem_en), .page(page)
  );

  regwin_evq #(.DEPTH(ISQ_DEPTH), .DW(16)) u_evq (
    .clk(clk), .rst_n(rst_n), .in_valid(evt_valid), .in_ready(evt_ready),
    .in_data(evt_data), .pop(pop), .empty(q_empty), .head(q_head),
    .count(q_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ptr_q    <= '0;
      rx_idx_q <= '0;
      tx_idx_q <= '0;
    end else begin
      rd_valid <= acc.vld && !acc.wr;
      if (acc.vld && !acc.wr) rd_data <= rd_next;
      if (acc.vld && acc.wr && is_ptr) ptr_q <= {acc.wdata[15:1], 1'b0};
      if (acc.vld && is_dport) begin
        if (acc.wr)
          tx_idx_q <= (tx_idx_q == TXI'(TX_WORDS - 1)) ? '0 : tx_idx_q + 1'b1;
        else
          rx_idx_q <= (rx_idx_q == RXI'(RX_WORDS - 1)) ? '0 : rx_idx_q + 1'b1;
      end
      if (st_wr && st_addr[15:1] == A_TXCMD[15:1]) tx_idx_q <= '0;
    end
  end

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int ISQ_DEPTH = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           io_rd,
  input logic                           io_wr,
  input logic [3:0]                     io_addr,
  input logic                           mem_rd,
  input logic                           rd_valid,
  input logic [15:0]                    rd_data,
  input logic                           evt_valid,
  input logic [15:0]                    ptr_q,
  input logic                           mem_en,
  input logic [$clog2(ISQ_DEPTH+1)-1:0] q_count
);

  localparam int CW = $clog2(ISQ_DEPTH + 1);

  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(io_rd || mem_rd));

  p_wr_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> !rd_valid);

  p_ptr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[0] == 1'b0);

  p_ptr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr[3:1] == 3'd5) |=> (rd_valid && rd_data == $past(ptr_q)));

  p_isq_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr[3:1] == 3'd4 && q_count == '0) |=> (rd_data == 16'h0000));

  p_isq_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr[3:1] == 3'd4 && q_count != '0 && !evt_valid)
      |=> (q_count == $past(q_count) - CW'(1)));

  p_q_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(ISQ_DEPTH));

  p_mem_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd && !io_wr && !mem_en) |=> !rd_valid);

endmodule

bind regwin regwin_chk #(.ISQ_DEPTH(ISQ_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
  .mem_rd(mem_rd), .rd_valid(rd_valid), .rd_data(rd_data),
  .evt_valid(evt_valid), .ptr_q(ptr_q), .mem_en(mem_en), .q_count(q_count)
);

// File: tb/regwin_tb.sv
`timescale 1ns/1ps
module regwin_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_rd = 0, io_wr = 0, mem_rd = 0, mem_wr = 0;
  logic [3:0]  io_addr = '0;
  logic [19:0] host_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_valid, evt_ready;
  logic [15:0] rd_data;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  regwin u_dut (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .host_addr(host_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read result
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rd_valid", rd_data, 16'h0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic cyc(input logic ir, iw, mr, mw, input logic [3:0] ia,
                     input logic [19:0] ha, input logic [15:0] wd);
    @(negedge clk);
    io_rd = ir; io_wr = iw; mem_rd = mr; mem_wr = mw;
    io_addr = ia; host_addr = ha; wr_data = wd;
    @(negedge clk);
    io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic io_w(input logic [3:0] ia, input logic [15:0] d);
    cyc(0, 1, 0, 0, ia, '0, d);
  endtask

  task automatic io_r(input logic [3:0] ia, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    cyc(1, 0, 0, 0, ia, '0, '0);
  endtask

  task automatic pw(input logic [15:0] a, input logic [15:0] d);
    io_w(4'hA, a); io_w(4'hC, d);
  endtask

  task automatic pr(input logic [15:0] a, input logic [15:0] e, input string tag);
    io_w(4'hA, a); io_r(4'hC, e, tag);
  endtask

  task automatic mem_r(input logic [19:0] ha, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    cyc(0, 0, 1, 0, 4'h0, ha, '0);
  endtask

  task automatic mem_w(input logic [19:0] ha, input logic [15:0] d);
    cyc(0, 0, 0, 1, 4'h0, ha, d);
  endtask

  task automatic none(input logic ir, iw, mr, mw, input logic [3:0] ia,
                      input logic [19:0] ha, input logic [15:0] wd, input string tag);
    cyc(ir, iw, mr, mw, ia, ha, wd);
    check(rd_valid == 1'b0, tag, {15'd0, rd_valid}, 16'h0);
  endtask

  task automatic push_evt(input logic [15:0] d, input bit exp_rdy, input string tag);
    @(negedge clk);
    evt_valid = 1'b1; evt_data = d;
    check(evt_ready == exp_rdy, tag, {15'd0, evt_ready}, {15'd0, exp_rdy});
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 16'h0, 16'h0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rd_valid == 1'b0, "R1 rd_valid after reset", {15'd0, rd_valid}, 16'h0);
    check(evt_ready == 1'b1, "R1 evt_ready after reset", {15'd0, evt_ready}, 16'h1);
    io_r(4'hA, 16'h0000, "R1 pointer after reset");
    none(0, 0, 1, 0, 4'h0, 20'h00150, '0, "R1 memory read ignored in I/O mode");
    io_r(4'h8, 16'h0000, "R5 empty queue reads zero");

    // R2 pointer
    io_w(4'hA, 16'h0151);
    io_r(4'hA, 16'h0150, "R2 pointer bit0 cleared");
    io_r(4'hA, 16'h0150, "R2 pointer no auto increment");

    // R3 data window words
    io_w(4'hC, 16'h1234);
    io_w(4'hE, 16'hABCD);
    pr(16'h0152, 16'hABCD, "R3 high word at pointer+2");
    io_w(4'hA, 16'h0150);
    io_r(4'hE, 16'hABCD, "R3 read via 0x0E");
    io_r(4'hC, 16'h1234, "R3 read via 0x0C");

    // R4 shortcut aliasing
    io_w(4'h4, 16'h00C9);
    pr(16'h0144, 16'h00C9, "R4 txcmd shortcut to 0x0144");
    pw(16'h0146, 16'h05EE);
    io_r(4'h6, 16'h05EE, "R4 0x0146 seen at txlen shortcut");

    // R8 unmapped space
    pw(16'h0046, 16'hFFFF);
    pr(16'h0046, 16'h0000, "R8 0x0046 unmapped");
    pw(16'h0200, 16'hFFFF);
    pr(16'h0200, 16'h0000, "R8 0x0200 unmapped");
    pw(16'h015A, 16'hFFFF);
    pr(16'h015A, 16'h0000, "R8 0x015A unmapped");
    pw(16'h1150, 16'hFFFF);
    pr(16'h1150, 16'h0000, "R8 0x1150 unmapped");
    pr(16'h0150, 16'h1234, "R8 aliasing write left 0x0150 intact");

    // R9 transmit fill with wrap
    for (int i = 0; i < 17; i++)
      io_w((i % 2 == 0) ? 4'h0 : 4'h2, 16'h1000 + 16'(i));
    pr(16'h0A00, 16'h1010, "R9 wrap overwrote first word");
    pr(16'h0A02, 16'h1001, "R9 second word");
    pr(16'h0A1E, 16'h100F, "R9 last word");
    io_w(4'h4, 16'h0001);
    io_w(4'h2, 16'h7777);
    pr(16'h0A00, 16'h7777, "R9 txcmd shortcut resets fill");
    pr(16'h0A02, 16'h1001, "R9 next word untouched");
    pw(16'h0144, 16'h0002);
    io_w(4'h0, 16'h8888);
    pr(16'h0A00, 16'h8888, "R9 txcmd via pointer resets fill");
    io_r(4'h4, 16'h0002, "R4 pointer write seen at txcmd shortcut");

    // R10 receive read with wrap
    for (int i = 0; i < 16; i++) pw(16'h0400 + 16'(2 * i), 16'h2000 + 16'(i));
    for (int i = 0; i < 16; i++)
      io_r((i % 2 == 0) ? 4'h0 : 4'h2, 16'h2000 + 16'(i), "R10 receive sequence");
    io_r(4'h0, 16'h2000, "R10 receive wrap");

    // R6 / R5 / R12 event queue
    for (int i = 0; i < 4; i++) push_evt(16'hE001 + 16'(i), 1'b1, "R6 ready while not full");
    push_evt(16'hE005, 1'b0, "R6 ready low when full");
    io_r(4'h8, 16'hE001, "R5 oldest event first");
    pr(16'h0120, 16'hE002, "R5 pop via internal 0x0120");
    io_w(4'h8, 16'hDEAD);
    pw(16'h0120, 16'hBEEF);
    io_r(4'h8, 16'hE003, "R12 writes left queue unchanged");
    io_r(4'h8, 16'hE004, "R6 refused word not stored (last)");
    io_r(4'h8, 16'h0000, "R6 queue empty after drain");

    // R7 memory mode
    pw(16'h0022, 16'h00C3);
    pw(16'h0020, 16'h0001);
    mem_r(20'hC3150, 16'h1234, "R7 memory read in page");
    mem_w(20'hC3152, 16'h4444);
    pr(16'h0152, 16'h4444, "R7 memory write seen via pointer");
    none(0, 0, 1, 0, 4'h0, 20'hC4150, '0, "R7 memory read outside page ignored");
    mem_r(20'hC3146, 16'h05EE, "R4 txlen seen on memory path");
    mem_r(20'hC3120, 16'h0000, "R5 memory read of empty queue");
    push_evt(16'hE00A, 1'b1, "R6 accept after drain");
    mem_r(20'hC3120, 16'hE00A, "R5 memory pop of queue");

    // R11 priority
    none(1, 1, 0, 0, 4'hA, '0, 16'h0300, "R11 io_wr beats io_rd");
    io_r(4'hA, 16'h0300, "R11 write taken");
    exp_q.push_back(16'h0300); tag_q.push_back("R11 io_rd beats mem_rd");
    cyc(1, 0, 1, 0, 4'hA, 20'hC3150, '0);
    @(negedge clk);
    check(rd_valid == 1'b0, "R11 single result for two strobes", {15'd0, rd_valid}, 16'h0);
    none(0, 0, 1, 1, 4'h0, 20'hC3150, 16'h5555, "R11 mem_wr beats mem_rd");
    mem_r(20'hC3150, 16'h5555, "R11 memory write taken");

    // R7 disable memory path again
    mem_w(20'hC3020, 16'h0000);
    none(0, 0, 1, 0, 4'h0, 20'hC3150, '0, "R7 memory read ignored after disable");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all expected reads returned", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule